// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block receives asynchronous serial frames on one idle-high line. A clock-enable pulse arrives at sixteen times the bit rate, and the block samples the line on each pulse. A falling edge starts a frame candidate. The candidate is confirmed half a bit later. The block then collects 7 or 8 data bits with the least significant bit first. After the data it collects an optional parity bit and one or two stop bits, then judges the frame.

Each judged byte goes into a 16-entry queue together with two tags: a parity-error tag and a framing-error tag. A parity or framing problem never stops reception. Three sticky flags record events:
- an overrun, when a frame arrives while the queue is full;
- a break, when a framing error arrives with all data bits zero;
- a receive error, when any frame carries a parity or framing error.

While the overrun flag or the break flag is set, completed frames are discarded. Three level interrupt lines report queue readiness, receive errors, and break/overrun. They are gated by two enables whose coverage overlaps. The consumer reads the queue head and pops it with a pulse, and clears each flag with a write-1 pulse.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_level` is 0 and all three flags and all three interrupt lines are 0.
- R2: A low pulse on `rxd` that is high again at the confirmation point is discarded, and no byte is queued. The confirmation point is 8 sample ticks after the falling edge is seen.
- R3: Data bits are assembled least significant bit first. With `cfg_len7`=1, seven bits are taken and `rd_data[7]` reads 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. On a mismatch, `rd_perr`=1 is stored with the byte, the byte is still queued, and the next frame is received normally.
- R5: A 0 on the first stop bit stores the byte with `rd_ferr`=1. With `cfg_two_stop`=1, the second stop bit is not checked.
- R6: The queue holds 16 entries. It returns bytes in arrival order, with `rd_data`/`rd_perr`/`rd_ferr` showing the oldest entry. A `pop` pulse on an empty queue has no effect.
- R7: A completed frame is queued only if the queue is not full and both `flag_ovr` and `flag_brk` are 0. Otherwise it is dropped.
- R8: A frame completing while the queue is full sets `flag_ovr`. The flag holds until a `clr_ovr` pulse.
- R9: A framing error with all data bits 0 (and a 0 parity bit when parity is on) sets `flag_brk`. The flag holds until a `clr_brk` pulse. The receiver then waits for the line to return high before looking for a start.
- R10: `flag_err` is set by any frame with a parity or framing error. It holds until a `clr_err` pulse.
- R11: `irq_rx` = `ie_rx` AND ready. `irq_err` = (`ie_rx` OR `ie_err`) AND `flag_err`. `irq_bo` = (`ie_rx` OR `ie_err`) AND (`flag_brk` OR `flag_ovr`).
- R12: Ready means `rx_level` is at least `cfg_thresh`. A `cfg_thresh` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len7 | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_thresh | input | 5 | Ready threshold (0 treated as 1) |
| ie_rx | input | 1 | Receive enable for all three lines |
| ie_err | input | 1 | Enable for error and break/overrun lines |
| pop | input | 1 | Remove queue head |
| clr_ovr | input | 1 | Write-1 clear of overrun flag |
| clr_brk | input | 1 | Write-1 clear of break flag |
| clr_err | input | 1 | Write-1 clear of error flag |
| rd_data | output | 8 | Queue head data |
| rd_perr | output | 1 | Queue head parity-error tag |
| rd_ferr | output | 1 | Queue head framing-error tag |
| rx_level | output | 5 | Entries in queue |
| flag_ovr | output | 1 | Sticky overrun |
| flag_brk | output | 1 | Sticky break |
| flag_err | output | 1 | Sticky parity/framing error |
| irq_rx | output | 1 | Ready interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_bo | output | 1 | Break/overrun interrupt |

## Verification
The properties assume the frame-format inputs hold steady while a frame is in flight. They also assume the clear inputs are single-cycle pulses, so the sticky-flag properties only apply in cycles without a clear. The stimulus changes the format only between frames, when the line is idle. It pulses each clear for one cycle, and it keeps every line level stable for whole bit times, apart from the deliberate short glitch and the shortened second stop bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned OSR = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5,
    ST_WAITH = 3'd6
  } rx_state_e;

  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int unsigned OS = OSR
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic     len7,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     two_stop,
  output logic     done,
  output rx_word_t word,
  output logic     brk_det
);
  localparam int unsigned CW   = $clog2(OS);
  localparam int unsigned HALF = OS / 2;

  rx_state_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    idx_q, idx_n;
  logic [7:0]    sh_q, sh_n;
  logic          pb_q, pb_n;
  logic          bit_end;
  logic [2:0]    last_idx;

  assign bit_end  = (cnt_q == CW'(OS - 1));
  assign last_idx = len7 ? 3'd6 : 3'd7;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    sh_n  = sh_q;
    pb_n  = pb_q;
    done  = 1'b0;
    if (tick) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!line) begin
            st_n  = ST_START;
            cnt_n = '0;
          end
        end
        ST_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_n = '0;
            if (!line) begin
              st_n  = ST_DATA;
              idx_n = '0;
              sh_n  = '0;
              pb_n  = 1'b0;
            end else begin
              st_n = ST_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          cnt_n = cnt_q + 1'b1;
          if (bit_end) begin
            sh_n[idx_q] = line;
            if (idx_q == last_idx) st_n = par_en ? ST_PAR : ST_STOP1;
            else                   idx_n = idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          cnt_n = cnt_q + 1'b1;
          if (bit_end) begin
            pb_n = line;
            st_n = ST_STOP1;
          end
        end
        ST_STOP1: begin
          cnt_n = cnt_q + 1'b1;
          if (bit_end) begin
            done = 1'b1;
            if (!line)         st_n = ST_WAITH;
            else if (two_stop) st_n = ST_STOP2;
            else               st_n = ST_IDLE;
          end
        end
        ST_STOP2: begin
          cnt_n = cnt_q + 1'b1;
          if (bit_end) st_n = ST_IDLE;
        end
        ST_WAITH: begin
          if (line) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      sh_q  <= sh_n;
      pb_q  <= pb_n;
    end
  end

  assign word.data = sh_q;
  assign word.perr = par_en & (^sh_q ^ pb_q ^ par_odd);
  assign word.ferr = ~line;
  assign brk_det   = ~line & (sh_q == 8'h00) & ~(par_en & pb_q);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [$clog2(DEPTH):0] level,
  output logic         full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          do_pop;

  assign full   = (cnt_q == LW'(DEPTH));
  assign do_pop = pop & (cnt_q != '0);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (!push && do_pop) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign head  = mem[rp_q];
  assign level = cnt_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          cfg_len7,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic [LW-1:0] cfg_thresh,
  input  logic          ie_rx,
  input  logic          ie_err,
  input  logic          pop,
  input  logic          clr_ovr,
  input  logic          clr_brk,
  input  logic          clr_err,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic [LW-1:0] rx_level,
  output logic          flag_ovr,
  output logic          flag_brk,
  output logic          flag_err,
  output logic          irq_rx,
  output logic          irq_err,
  output logic          irq_bo
);
  localparam int unsigned WW = $bits(rx_word_t);

  logic     line_s;
  logic     done;
  logic     brk_det;
  logic     full;
  logic     push;
  rx_word_t word;
  rx_word_t head;
  logic     ovr_q, ovr_n, brk_q, brk_n, err_q, err_n;
  logic [LW-1:0] thr_eff;
  logic     ready;

  srx_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  srx_framer #(.OS(OSR)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (os_tick),
    .line    (line_s),
    .len7    (cfg_len7),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .two_stop(cfg_two_stop),
    .done    (done),
    .word    (word),
    .brk_det (brk_det)
  );

  assign push = done & ~full & ~ovr_q & ~brk_q;

  srx_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .wdata(word),
    .pop  (pop),
    .head (head),
    .level(rx_level),
    .full (full)
  );

  always_comb begin
    ovr_n = (ovr_q & ~clr_ovr) | (done & full);
    brk_n = (brk_q & ~clr_brk) | (done & brk_det);
    err_n = (err_q & ~clr_err) | (done & (word.perr | word.ferr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovr_q <= ovr_n;
      brk_q <= brk_n;
      err_q <= err_n;
    end
  end

  assign thr_eff  = (cfg_thresh == '0) ? LW'(1) : cfg_thresh;
  assign ready    = (rx_level >= thr_eff);

  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign flag_ovr = ovr_q;
  assign flag_brk = brk_q;
  assign flag_err = err_q;
  assign irq_rx   = ie_rx & ready;
  assign irq_err  = (ie_rx | ie_err) & err_q;
  assign irq_bo   = (ie_rx | ie_err) & (brk_q | ovr_q);
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          full,
  input logic          flag_ovr,
  input logic          flag_brk,
  input logic          flag_err,
  input logic          clr_ovr,
  input logic          clr_brk,
  input logic          clr_err,
  input logic [LW-1:0] rx_level,
  input logic          ie_rx,
  input logic          ie_err,
  input logic          irq_rx,
  input logic          irq_err,
  input logic          irq_bo
);
  // R7: storing needs space and both blocking flags clear
  a_r7_push_gated: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full && !flag_ovr && !flag_brk));

  // R6: occupancy never exceeds the queue depth
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  // R8: overrun flag holds until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovr && !clr_ovr) |=> flag_ovr);

  // R9: break flag holds until cleared
  a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_brk && !clr_brk) |=> flag_brk);

  // R10: error flag holds until cleared
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_err && !clr_err) |=> flag_err);

  // R11: with both enables low every request line is quiet
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_rx && !ie_err) |-> (!irq_rx && !irq_err && !irq_bo));
endmodule

bind serial_rx_core srx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .push    (push),
  .full    (full),
  .flag_ovr(flag_ovr),
  .flag_brk(flag_brk),
  .flag_err(flag_err),
  .clr_ovr (clr_ovr),
  .clr_brk (clr_brk),
  .clr_err (clr_err),
  .rx_level(rx_level),
  .ie_rx   (ie_rx),
  .ie_err  (ie_err),
  .irq_rx  (irq_rx),
  .irq_err (irq_err),
  .irq_bo  (irq_bo)
);

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
  localparam int BITCLK = 32;

  logic       clk, rst_n, os_tick, rxd;
  logic       cfg_len7, cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic [4:0] cfg_thresh;
  logic       ie_rx, ie_err, pop, clr_ovr, clr_brk, clr_err;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr;
  logic [4:0] rx_level;
  logic       flag_ovr, flag_brk, flag_err, irq_rx, irq_err, irq_bo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  serial_rx_core u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line_for(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input bit stop1_low, input bit stop2_short_low);
    int n;
    logic p;
    logic [7:0] m;
    n = cfg_len7 ? 7 : 8;
    m = cfg_len7 ? (d & 8'h7F) : d;
    line_for(1'b0, BITCLK);
    for (int i = 0; i < n; i++) line_for(m[i], BITCLK);
    if (cfg_par_en) begin
      p = ^m ^ cfg_par_odd ^ bad_par;
      line_for(p, BITCLK);
    end
    line_for(~stop1_low, BITCLK);
    if (cfg_two_stop) begin
      if (stop2_short_low) begin
        line_for(1'b0, 12);
        line_for(1'b1, BITCLK - 12);
      end else begin
        line_for(1'b1, BITCLK);
      end
    end
    line_for(1'b1, BITCLK);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_expect(input string tag, input int d, input int pe, input int fe);
    chk({tag, " data"}, rd_data, d);
    chk({tag, " perr"}, rd_perr, pe);
    chk({tag, " ferr"}, rd_ferr, fe);
    pulse(pop);
  endtask

  task automatic set_fmt(input bit l7, input bit pe, input bit po, input bit ts);
    cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
  endtask

  task automatic t_reset;
    chk("R1 level", rx_level, 0);
    chk("R1 flags", {flag_ovr, flag_brk, flag_err}, 0);
    chk("R1 irqs", {irq_rx, irq_err, irq_bo}, 0);
  endtask

  task automatic t_basic;
    set_fmt(0, 0, 0, 0);
    send_frame(8'hA5, 0, 0, 0);
    send_frame(8'h3C, 0, 0, 0);
    chk("R6 level two", rx_level, 2);
    pop_expect("R3 first", 8'hA5, 0, 0);
    pop_expect("R6 second", 8'h3C, 0, 0);
    pulse(pop);
    chk("R6 pop on empty", rx_level, 0);
    send_frame(8'h01, 0, 0, 0);
    pop_expect("R6 after empty pop", 8'h01, 0, 0);
  endtask

  task automatic t_len7;
    set_fmt(1, 0, 0, 0);
    send_frame(8'hFF, 0, 0, 0);
    send_frame(8'h00, 0, 0, 0);
    send_frame(8'h55, 0, 0, 0);
    pop_expect("R3 seven bits", 8'h7F, 0, 0);
    pop_expect("R3 seven zero", 8'h00, 0, 0);
    pop_expect("R3 seven pattern", 8'h55, 0, 0);
  endtask

  task automatic t_parity;
    set_fmt(0, 1, 0, 0);
    send_frame(8'h96, 0, 0, 0);
    chk("R10 no error yet", flag_err, 0);
    send_frame(8'h96, 1, 0, 0);
    set_fmt(0, 1, 1, 0);
    send_frame(8'h07, 0, 0, 0);
    send_frame(8'h07, 1, 0, 0);
    chk("R4 all kept", rx_level, 4);
    pop_expect("R4 even good", 8'h96, 0, 0);
    pop_expect("R4 even bad", 8'h96, 1, 0);
    pop_expect("R4 odd good", 8'h07, 0, 0);
    pop_expect("R4 odd bad", 8'h07, 1, 0);
    chk("R10 set", flag_err, 1);
    pulse(clr_err);
    chk("R10 cleared", flag_err, 0);
  endtask

  task automatic t_stop;
    set_fmt(0, 0, 0, 0);
    send_frame(8'h81, 0, 1, 0);
    set_fmt(0, 0, 0, 1);
    send_frame(8'h42, 0, 0, 1);
    send_frame(8'h24, 0, 0, 0);
    chk("R5 level", rx_level, 3);
    pop_expect("R5 framing tag", 8'h81, 0, 1);
    pop_expect("R5 second stop unchecked", 8'h42, 0, 0);
    pop_expect("R5 next frame", 8'h24, 0, 0);
    chk("R9 no break", flag_brk, 0);
    pulse(clr_err);
  endtask

  task automatic t_glitch;
    set_fmt(0, 0, 0, 0);
    line_for(1'b0, 8);
    line_for(1'b1, 3 * BITCLK);
    chk("R2 glitch ignored", rx_level, 0);
    send_frame(8'hC3, 0, 0, 0);
    pop_expect("R2 after glitch", 8'hC3, 0, 0);
  endtask

  task automatic t_irq;
    set_fmt(0, 0, 0, 0);
    ie_rx = 1; ie_err = 0; cfg_thresh = 2;
    send_frame(8'h11, 0, 0, 0);
    chk("R12 below thresh", irq_rx, 0);
    send_frame(8'h22, 0, 0, 0);
    chk("R12 at thresh", irq_rx, 1);
    pulse(pop); pulse(pop);
    cfg_thresh = 0;
    send_frame(8'h33, 0, 0, 0);
    chk("R12 zero acts as one", irq_rx, 1);
    ie_rx = 0;
    @(negedge clk);
    chk("R11 rx gated", irq_rx, 0);
    pulse(pop);
    send_frame(8'h44, 1'b0, 1'b1, 0);
    chk("R11 err quiet", irq_err, 0);
    ie_err = 1;
    @(negedge clk);
    chk("R11 err via ie_err", irq_err, 1);
    chk("R11 rx off with ie_err", irq_rx, 0);
    ie_err = 0; ie_rx = 1;
    @(negedge clk);
    chk("R11 err via ie_rx", irq_err, 1);
    pulse(clr_err);
    chk("R11 err drops", irq_err, 0);
    pulse(pop);
    ie_rx = 0; cfg_thresh = 1;
  endtask

  task automatic t_overrun;
    set_fmt(0, 0, 0, 0);
    for (int i = 0; i < 16; i++) send_frame(8'(i + 1), 0, 0, 0);
    chk("R8 full", rx_level, 16);
    chk("R8 no flag yet", flag_ovr, 0);
    send_frame(8'hEE, 0, 0, 0);
    chk("R8 set", flag_ovr, 1);
    chk("R8 not stored", rx_level, 16);
    ie_err = 1;
    @(negedge clk);
    chk("R11 bo via ie_err", irq_bo, 1);
    ie_err = 0;
    pulse(pop);
    send_frame(8'hDD, 0, 0, 0);
    chk("R7 dropped while ovr", rx_level, 15);
    pulse(clr_ovr);
    chk("R8 cleared", flag_ovr, 0);
    send_frame(8'h77, 0, 0, 0);
    chk("R7 stored again", rx_level, 16);
    for (int i = 1; i < 16; i++) pop_expect("R6 order", i + 1, 0, 0);
    pop_expect("R8 after clear", 8'h77, 0, 0);
  endtask

  task automatic t_break;
    set_fmt(0, 0, 0, 0);
    line_for(1'b0, 10 * BITCLK + 3 * BITCLK);
    line_for(1'b1, 2 * BITCLK);
    chk("R9 set", flag_brk, 1);
    chk("R9 one entry", rx_level, 1);
    chk("R9 zero tagged", {rd_data, rd_ferr}, 1);
    send_frame(8'h5A, 0, 0, 0);
    chk("R7 dropped while brk", rx_level, 1);
    pulse(clr_brk);
    pulse(clr_err);
    chk("R9 cleared", flag_brk, 0);
    send_frame(8'h5A, 0, 0, 0);
    chk("R9 resumes", rx_level, 2);
    pulse(pop);
    pop_expect("R9 next byte", 8'h5A, 0, 0);
  endtask

  initial begin
    rst_n = 0; rxd = 1; pop = 0; clr_ovr = 0; clr_brk = 0; clr_err = 0;
    ie_rx = 0; ie_err = 0; cfg_thresh = 1;
    set_fmt(0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_len7();
    t_parity();
    t_stop();
    t_glitch();
    t_irq();
    t_overrun();
    t_break();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule